// File: doc/BRIEF.md
# Dual Alarm Compare and Interrupt Flag Unit

This block keeps two alarm register sets next to a clock/calendar counter. Each set holds a seconds, minutes, hours, weekday, date and month value laid out like the live time fields. On every seconds tick, each enabled alarm is compared with the current time. When all six fields are equal, that alarm's interrupt flag is set. Only a software write clears the flag.

A single output pin signals alarms. Its active level comes from a polarity bit held in the first alarm's weekday byte. The second alarm shows that same bit instead of keeping its own. The pin rests at the inverse of the polarity while no enabled alarm has its flag set. The 12/24-hour indicator in each alarm's hours byte is a read-only reflection of the main hour-format input.

Register writes and reads use a byte-wide address/data port. Reads are combinational. The two alarm sets sit at two base addresses with one reserved byte after each set.

Top module: `alm_dual_unit`

## Requirements
- R1: After reset all alarm fields, both flags and the polarity bit are zero, `alm_flag` is 00 and `mfp` is 1.
- R2: Alarm 0 sits at base 0x0A and alarm 1 at base 0x11. Offsets within a set: +0 seconds (bits 6:0), +1 minutes (bits 6:0), +2 hours (bits 5:0), +3 weekday byte (bit 7 polarity, bit 3 flag, bits 2:0 weekday), +4 date (bits 5:0), +5 month (bits 4:0). A written field reads back, and bits outside these fields read 0.
- R3: Bit 6 of each alarm's hours byte reads as the `hr12` input. Writing that bit has no effect.
- R4: Bit 7 of alarm 1's weekday byte reads as alarm 0's polarity bit. Writing bit 7 at alarm 1 changes nothing.
- R5: On a clock edge with `sec_tick` high, alarm n's flag is set if `alm_en[n]` is 1 and all six of its fields equal the current time inputs. `alm_en` value 01 enables alarm 0 only, 10 alarm 1 only, 11 both, 00 neither. `alm_flag[n]` shows the flag.
- R6: A flag is not set without a tick, while its alarm is disabled, or when any single field differs.
- R7: A flag is cleared only by writing its weekday byte with bit 3 = 0. Writing bit 3 = 1 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R8: `mfp` equals the polarity bit while any alarm has both its flag and its enable bit at 1, and equals the inverse of the polarity bit otherwise. With default parameters it follows in the same cycle as the flag.
- R9: Writes to the reserved bytes 0x10 and 0x17, and to any address outside the two sets, are ignored. Reads there return 0.
- R10: The two flags are independent: setting or clearing one never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| alm_en | input | 2 | Alarm enables from the control byte (bit 0 alarm 0, bit 1 alarm 1) |
| hr12 | input | 1 | Main hour format, 1 = 12-hour |
| cur_sec | input | 7 | Current BCD seconds |
| cur_min | input | 7 | Current BCD minutes |
| cur_hour | input | 6 | Current BCD hour byte bits 5:0 |
| cur_wday | input | 3 | Current weekday |
| cur_date | input | 6 | Current BCD date |
| cur_mon | input | 5 | Current BCD month |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational |
| alm_flag | output | 2 | Interrupt flags |
| mfp | output | 1 | Multi-function pin level |

## Verification
The bench builds the unit with `ADDR_W` = 5, so the whole 32-byte address space can be swept for every write/read pattern. This covers both alarm sets, the reserved bytes and the unmapped addresses in each pass. It keeps the default bases and the combinational pin, so the pin level can be checked in the cycle its flag changes. All four enable codes, a one-bit mismatch in each of the six fields, both polarities and a simultaneous set and clear are then driven against a byte-level model kept in the bench.

// File: rtl/alm_dual_pkg.sv
package alm_dual_pkg;
   localparam int FIELDS = 6;
   localparam int BYTE_W = 8;

   localparam logic [2:0] OFS_SEC  = 3'd0;
   localparam logic [2:0] OFS_MIN  = 3'd1;
   localparam logic [2:0] OFS_HOUR = 3'd2;
   localparam logic [2:0] OFS_WDAY = 3'd3;
   localparam logic [2:0] OFS_DATE = 3'd4;
   localparam logic [2:0] OFS_MON  = 3'd5;

   localparam int SEC_W  = 7;
   localparam int MIN_W  = 7;
   localparam int HOUR_W = 6;
   localparam int WDAY_W = 3;
   localparam int DATE_W = 6;
   localparam int MON_W  = 5;

   localparam int POL_BIT  = 7;
   localparam int FMT_BIT  = 6;
   localparam int FLAG_BIT = 3;

   typedef struct packed {
      logic [SEC_W-1:0]  sec;
      logic [MIN_W-1:0]  min;
      logic [HOUR_W-1:0] hour;
      logic [WDAY_W-1:0] wday;
      logic [DATE_W-1:0] date;
      logic [MON_W-1:0]  mon;
   } alm_time_t;
endpackage

// File: rtl/alm_dual_bank.sv
module alm_dual_bank
   import alm_dual_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int BASE    = 10,
   parameter bit HAS_POL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              hr12,
   input  logic              pol_in,
   input  logic              set_flag,
   output alm_time_t         fld,
   output logic              flag,
   output logic              pol_out,
   output logic [BYTE_W-1:0] rd_data
);
   localparam int LAST = BASE + FIELDS;
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

   logic       wr_hit, rd_hit, wr_sel, clr_req;
   logic [2:0] wr_ofs, rd_ofs;

   assign wr_hit  = (int'(wr_addr) >= BASE) && (int'(wr_addr) < LAST);
   assign rd_hit  = (int'(rd_addr) >= BASE) && (int'(rd_addr) < LAST);
   assign wr_ofs  = 3'(wr_addr - BASE_A);
   assign rd_ofs  = 3'(rd_addr - BASE_A);
   assign wr_sel  = wr_en && wr_hit;
   assign clr_req = wr_sel && (wr_ofs == OFS_WDAY) && !wr_data[FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fld <= '0;
      end else if (wr_sel) begin
         case (wr_ofs)
            OFS_SEC:  fld.sec  <= wr_data[SEC_W-1:0];
            OFS_MIN:  fld.min  <= wr_data[MIN_W-1:0];
            OFS_HOUR: fld.hour <= wr_data[HOUR_W-1:0];
            OFS_WDAY: fld.wday <= wr_data[WDAY_W-1:0];
            OFS_DATE: fld.date <= wr_data[DATE_W-1:0];
            OFS_MON:  fld.mon  <= wr_data[MON_W-1:0];
            default: ;
         endcase
      end
   end

   // hardware set has priority over a software clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (set_flag) flag <= 1'b1;
      else if (clr_req)  flag <= 1'b0;
   end

   generate
      if (HAS_POL) begin : g_own_pol
         logic pol_q;
         logic unused_pol_in;
         assign unused_pol_in = pol_in;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              pol_q <= 1'b0;
            else if (wr_sel && wr_ofs == OFS_WDAY)   pol_q <= wr_data[POL_BIT];
         end
         assign pol_out = pol_q;
      end else begin : g_mirror_pol
         logic unused_pol_bit;
         assign unused_pol_bit = wr_data[POL_BIT];
         assign pol_out = pol_in;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_hit) begin
         case (rd_ofs)
            OFS_SEC:  rd_data = BYTE_W'(fld.sec);
            OFS_MIN:  rd_data = BYTE_W'(fld.min);
            OFS_HOUR: rd_data = {1'b0, hr12, fld.hour};
            OFS_WDAY: rd_data = {pol_out, 3'b000, flag, fld.wday};
            OFS_DATE: rd_data = BYTE_W'(fld.date);
            OFS_MON:  rd_data = BYTE_W'(fld.mon);
            default:  rd_data = '0;
         endcase
      end
   end

   p_flag_rise_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !$past(flag)) |-> $past(set_flag));
   p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_flag |=> flag);
   p_flag_fall_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flag) && !flag) |-> $past(clr_req && !set_flag));
   p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_flag && !clr_req) |=> (flag == $past(flag)));
endmodule

// File: rtl/alm_dual_cmp.sv
module alm_dual_cmp
   import alm_dual_pkg::*;
(
   input  alm_time_t alm,
   input  alm_time_t now,
   output logic      match
);
   logic [FIELDS-1:0] eq;

   assign eq[OFS_SEC]  = (alm.sec  == now.sec);
   assign eq[OFS_MIN]  = (alm.min  == now.min);
   assign eq[OFS_HOUR] = (alm.hour == now.hour);
   assign eq[OFS_WDAY] = (alm.wday == now.wday);
   assign eq[OFS_DATE] = (alm.date == now.date);
   assign eq[OFS_MON]  = (alm.mon  == now.mon);
   assign match = &eq;
endmodule

// File: rtl/alm_dual_pin.sv
module alm_dual_pin #(
   parameter int N          = 2,
   parameter bit REGISTERED = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags,
   input  logic [N-1:0] en,
   input  logic         pol,
   output logic         pin
);
   logic active, level;

   assign active = |(flags & en);
   assign level  = active ? pol : ~pol;

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin <= 1'b1;
            else        pin <= level;
         end
         p_pin_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
            active |=> (pin == $past(pol)));
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign pin = level;
      end
   endgenerate
endmodule

// File: rtl/alm_dual_unit.sv
module alm_dual_unit
   import alm_dual_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int ALM0_BASE = 10,
   parameter int ALM1_BASE = 17,
   parameter bit PIN_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [1:0]        alm_en,
   input  logic              hr12,
   input  logic [6:0]        cur_sec,
   input  logic [6:0]        cur_min,
   input  logic [5:0]        cur_hour,
   input  logic [2:0]        cur_wday,
   input  logic [5:0]        cur_date,
   input  logic [4:0]        cur_mon,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic [1:0]        alm_flag,
   output logic              mfp
);
   localparam int NALM  = 2;
   localparam int RSVD0 = ALM0_BASE + FIELDS;
   localparam int RSVD1 = ALM1_BASE + FIELDS;

   if (ADDR_W < 3)
      $error("ADDR_W too small");
   if (ALM1_BASE < RSVD0)
      $error("alarm sets overlap");
   if (RSVD1 > (1 << ADDR_W))
      $error("alarm set exceeds address space");

   alm_time_t         now;
   alm_time_t         alm_fld [NALM];
   logic [7:0]        bank_rd [NALM];
   logic [NALM-1:0]   match_v, set_v, pol_v;

   assign now = {cur_sec, cur_min, cur_hour, cur_wday, cur_date, cur_mon};

   for (genvar g = 0; g < NALM; g++) begin : g_alm
      alm_dual_bank #(
         .ADDR_W (ADDR_W),
         .BASE   ((g == 0) ? ALM0_BASE : ALM1_BASE),
         .HAS_POL(g == 0)
      ) i_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .wr_addr (wr_addr),
         .wr_data (wr_data),
         .rd_addr (rd_addr),
         .hr12    (hr12),
         .pol_in  (pol_v[0]),
         .set_flag(set_v[g]),
         .fld     (alm_fld[g]),
         .flag    (alm_flag[g]),
         .pol_out (pol_v[g]),
         .rd_data (bank_rd[g])
      );

      alm_dual_cmp i_cmp (
         .alm  (alm_fld[g]),
         .now  (now),
         .match(match_v[g])
      );

      assign set_v[g] = sec_tick && alm_en[g] && match_v[g];

      p_flag_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (alm_flag[g] && !$past(alm_flag[g])) |-> $past(sec_tick && alm_en[g]));
   end

   assign rd_data = bank_rd[0] | bank_rd[1];

   alm_dual_pin #(
      .N         (NALM),
      .REGISTERED(PIN_REG)
   ) i_pin (
      .clk  (clk),
      .rst_n(rst_n),
      .flags(alm_flag),
      .en   (alm_en),
      .pol  (pol_v[0]),
      .pin  (mfp)
   );

   p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_addr) == RSVD0 || int'(rd_addr) == RSVD1) |-> (rd_data == 8'h00));
   p_pol_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_addr) == ALM1_BASE + 3) |-> (rd_data[POL_BIT] == pol_v[0]));
endmodule

// File: tb/test_alm_dual_unit.sv
module test_alm_dual_unit;
   localparam int AW = 5;
   localparam int B0 = 10;
   localparam int B1 = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sec_tick = 1'b0;
   logic [1:0]    alm_en = 2'b00;
   logic          hr12 = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic [1:0]    alm_flag;
   logic          mfp;
   logic [7:0]    cur [6];

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] m_f [2][6];
   logic       m_pol = 1'b0;
   logic [1:0] m_flag = 2'b00;

   always #5 clk = ~clk;

   alm_dual_unit #(.ADDR_W(AW), .ALM0_BASE(B0), .ALM1_BASE(B1)) i_alm_dual_unit (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .alm_en(alm_en), .hr12(hr12),
      .cur_sec(cur[0][6:0]), .cur_min(cur[1][6:0]), .cur_hour(cur[2][5:0]),
      .cur_wday(cur[3][2:0]), .cur_date(cur[4][5:0]), .cur_mon(cur[5][4:0]),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .alm_flag(alm_flag), .mfp(mfp));

   function automatic logic [7:0] fmask(int o);
      case (o)
         0, 1:    return 8'h7F;
         2, 4:    return 8'h3F;
         3:       return 8'h07;
         default: return 8'h1F;
      endcase
   endfunction

   function automatic int which(int a);
      if (a >= B0 && a < B0 + 6) return 0;
      if (a >= B1 && a < B1 + 6) return 1;
      return -1;
   endfunction

   function automatic logic [7:0] exp_rd(int a);
      int g = which(a);
      int o;
      if (g < 0) return 8'h00;
      o = a - ((g == 0) ? B0 : B1);
      if (o == 2) return m_f[g][o] | {1'b0, hr12, 6'b0};
      if (o == 3) return m_f[g][o] | {m_pol, 3'b0, m_flag[g], 3'b0};
      return m_f[g][o];
   endfunction

   function automatic logic exp_pin();
      return (|(m_flag & alm_en)) ? m_pol : ~m_pol;
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_wr(int a, logic [7:0] d);
      int g = which(a);
      int o;
      if (g < 0) return;
      o = a - ((g == 0) ? B0 : B1);
      m_f[g][o] = d & fmask(o);
      if (o == 3) begin
         if (g == 0) m_pol = d[7];
         if (!d[3]) m_flag[g] = 1'b0;
      end
   endtask

   task automatic wr(int a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_wr(a, d);
   endtask

   task automatic rd_chk(string req, int a);
      @(negedge clk);
      rd_addr = AW'(a);
      #1 chk(req, rd_data, exp_rd(a));
   endtask

   task automatic model_tick();
      for (int g = 0; g < 2; g++) begin
         logic m = 1'b1;
         for (int o = 0; o < 6; o++)
            if (m_f[g][o] != (cur[o] & fmask(o))) m = 1'b0;
         if (alm_en[g] && m) m_flag[g] = 1'b1;
      end
   endtask

   task automatic tick();
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      model_tick();
   endtask

   task automatic chk_out(string req);
      chk(req, {6'b0, alm_flag}, {6'b0, m_flag});
      chk(req, {7'b0, mfp}, {7'b0, exp_pin()});
   endtask

   task automatic load(int g, logic pol);
      for (int o = 0; o < 6; o++)
         wr(((g == 0) ? B0 : B1) + o, (o == 3) ? (cur[o] | {pol, 7'b0}) : cur[o]);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'hC9};
      cur = '{8'h45, 8'h30, 8'h12, 8'h03, 8'h21, 8'h09};
      for (int g = 0; g < 2; g++) for (int o = 0; o < 6; o++) m_f[g][o] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R9 reserved and unmapped reads
      chk_out("R1");
      for (int a = 0; a < 32; a++) rd_chk("R1", a);

      // R3 hour-format reflection
      hr12 = 1'b1;
      rd_chk("R3", B0 + 2);
      rd_chk("R3", B1 + 2);
      wr(B0 + 2, 8'hFF);
      rd_chk("R3", B0 + 2);
      hr12 = 1'b0;
      rd_chk("R3", B0 + 2);

      // R2 / R9 exhaustive address sweep per pattern
      foreach (pats[p]) begin
         for (int a = 0; a < 32; a++) wr(a, pats[p] ^ 8'(a));
         for (int a = 0; a < 32; a++) rd_chk((which(a) < 0) ? "R9" : "R2", a);
      end

      // R4 polarity mirror
      wr(B0 + 3, 8'h00);
      wr(B1 + 3, 8'h80);
      rd_chk("R4", B1 + 3);
      wr(B0 + 3, 8'h80);
      wr(B1 + 3, 8'h00);
      rd_chk("R4", B1 + 3);
      chk("R4", {7'b0, m_pol}, 8'h01);

      // R5 / R6 all enable codes with both alarms matching
      for (int e = 0; e < 4; e++) begin
         alm_en = 2'b00;
         load(0, 1'b0);
         load(1, 1'b0);
         alm_en = 2'(e);
         chk_out("R6");
         tick();
         chk_out("R5");
      end

      // R6 one-bit mismatch in each field
      alm_en = 2'b11;
      for (int f = 0; f < 6; f++) begin
         load(0, 1'b0);
         load(1, 1'b0);
         cur[f] = cur[f] ^ 8'h01;
         tick();
         chk_out("R6");
         cur[f] = cur[f] ^ 8'h01;
      end

      // R6 no tick, matching
      repeat (5) @(negedge clk);
      chk_out("R6");

      // R8 / R10 polarity 1, independent flags
      load(0, 1'b1);
      load(1, 1'b0);
      chk_out("R8");
      tick();
      chk_out("R8");
      wr(B0 + 3, cur[3] | 8'h88);
      chk_out("R7");
      wr(B0 + 3, cur[3] | 8'h80);
      chk_out("R10");
      wr(B1 + 3, cur[3]);
      chk_out("R8");

      // R8 pin returns to rest when enable drops with flag set
      tick();
      @(negedge clk);
      alm_en = 2'b00;
      #1 chk_out("R8");
      alm_en = 2'b10;
      #1 chk_out("R8");
      alm_en = 2'b11;

      // R7 set wins over same-cycle clear
      @(negedge clk);
      sec_tick = 1'b1;
      wr_en = 1'b1; wr_addr = AW'(B0 + 3); wr_data = cur[3] | 8'h80;
      @(negedge clk);
      sec_tick = 1'b0; wr_en = 1'b0;
      model_wr(B0 + 3, cur[3] | 8'h80);
      model_tick();
      chk_out("R7");
      chk("R7", {7'b0, alm_flag[0]}, 8'h01);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule